// File: doc/BRIEF.md
# Multi-Bank DRAM Command Scheduler

This block turns a stream of memory requests into a legal command sequence for a four-bank double-data-rate DRAM. A requester offers one operation at a time on a valid/ready port: a read or write (bank, row, column, auto-precharge flag), a close-every-bank request, or a mode-register load. The block tracks whether each bank is closed or open, and which row is open. It then emits the needed sequence of row-close, row-open and column commands on registered chip-select, row-strobe, column-strobe and write-enable pins, together with the bank and address lines.

Every command waits in the scheduler until all of the spacing limits that apply to it are met. Limits within a bank and limits between banks are checked at the same time. Each limit is a parameter counted in clock cycles. Per-bank down-counters cover open-to-column, open-to-close, close-to-open and open-to-open spacing. Shared counters cover open-to-open across banks, write-to-read turnaround and the quiet time after a mode load. A column command with auto-precharge may go out as soon as the row is ready for column access. The bank's internal close is then deferred until the minimum row-open time and the access recovery time have both passed, and the next open of that bank waits for the close-to-open time after that.

The control is a state machine with six states. ST_IDLE accepts a request and picks the next state. A read/write to a closed bank goes to ST_OPEN. A read/write to a bank open on another row goes to ST_CLOSE. A read/write that hits the open row goes to ST_ACCESS. A close-all request goes to ST_ALLCLOSE. A mode load goes to ST_ALLCLOSE when any bank is open, and to ST_MODE otherwise. The remaining transitions are these:
- ST_CLOSE issues a single-bank close and moves to ST_OPEN.
- ST_OPEN issues a row open and moves to ST_ACCESS.
- ST_ACCESS issues the column command and returns to ST_IDLE.
- ST_ALLCLOSE issues the all-bank close. It moves to ST_MODE for a pending mode load, and back to ST_IDLE otherwise.
- ST_MODE issues the mode load and returns to ST_IDLE.

Top module: `dram_cmd_sched`

## Requirements
- R1: After reset the pins carry NOP, `req_ready` is high and every bank is treated as closed.
- R2: Pin encodings {cs_n,ras_n,cas_n,we_n}: NOP 0111, row open 0011, read 0101, write 0100, close 0010, refresh 0001, mode load 0000. No other pattern appears, and refresh is never issued.
- R3: `req_op` encoding: 0 read, 1 write, 2 close-all, 3 mode load. A read/write to a closed bank issues open then access. A read/write that hits the open row issues the access only. A read/write that misses the open row issues close, open, then access. A row open carries the row on `addr_o`. An access carries the column on `addr_o[9:0]`. `ba_o` is the request's bank. An open never targets an open bank, and an access or close never targets a closed bank.
- R4: An access comes at least T_RCD (3) cycles after the open of its bank.
- R5: In one bank, a close comes at least T_RAS (8) cycles after the open. An open comes at least T_RP (3) cycles after the bank's close, and at least T_RC (11) cycles after the previous open.
- R6: Row opens in any two banks are at least T_RRD (2) cycles apart.
- R7: A close comes at least T_WDATA+T_WR (6) cycles after a write to that bank, and at least T_RTP (2) cycles after a read. A read comes at least T_WDATA+T_WTR (5) cycles after any write.
- R8: `addr_o[10]` on an access carries `req_ap`. With it set, the bank closes with no close command. The internal close falls at the later of open+T_RAS and the access recovery point, and the next open waits T_RP beyond that. For a write issued T_RCD after its open, this gives an open-to-open gap of 12 cycles.
- R9: A close-all request issues one close with `addr_o[10]`=1, once every open bank meets R5 and R7, and it leaves all banks closed.
- R10: A mode load issues a close-all first if any bank is open. It then waits until every bank may be opened and issues the load with `ba_o`=bank and `addr_o`=row. No command follows within T_MRD (2) cycles.
- R11: Each command is issued in the first cycle its limits allow.
- R12: `req_ready` is high only in ST_IDLE. It stays low from acceptance until the request's last command is on the pins, and it stays high while no request is offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_op | input | 2 | Operation code (R3) |
| req_bank | input | BA_W | Target bank |
| req_row | input | ROW_W | Row, or mode-load operand |
| req_col | input | COL_W | Column |
| req_ap | input | 1 | Auto-precharge on access |
| cs_n | output | 1 | Registered chip select |
| ras_n | output | 1 | Registered row strobe |
| cas_n | output | 1 | Registered column strobe |
| we_n | output | 1 | Registered write enable |
| ba_o | output | BA_W | Registered bank address |
| addr_o | output | ROW_W | Registered address |

## Verification
A wrong open/closed flag or a wrong stored row shows up within the same request: an extra or missing close or open changes the number of commands issued before `req_ready` rises again. A counter loaded too small lets a command onto the pins too early. That breaks a spacing rule checked in the very cycle the command appears. A counter loaded too large, or a gate that is too strict, widens the exact gaps checked in the directed cases, which are measured from the first legal cycle.

// File: rtl/dsched_pkg.sv
package dsched_pkg;

    typedef enum logic [1:0] {
        OP_READ   = 2'd0,
        OP_WRITE  = 2'd1,
        OP_PREALL = 2'd2,
        OP_MODE   = 2'd3
    } op_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLOSE,
        ST_OPEN,
        ST_ACCESS,
        ST_ALLCLOSE,
        ST_MODE
    } st_t;

    // {cs_n, ras_n, cas_n, we_n}
    localparam logic [3:0] CMD_NOP = 4'b0111;
    localparam logic [3:0] CMD_ACT = 4'b0011;
    localparam logic [3:0] CMD_RD  = 4'b0101;
    localparam logic [3:0] CMD_WR  = 4'b0100;
    localparam logic [3:0] CMD_PRE = 4'b0010;
    localparam logic [3:0] CMD_REF = 4'b0001;
    localparam logic [3:0] CMD_MRS = 4'b0000;

endpackage

// File: rtl/dsched_bank_timer.sv
module dsched_bank_timer #(
    parameter int CNT_W  = 5,
    parameter int ROW_W  = 13,
    parameter int T_RCD  = 3,
    parameter int T_RP   = 3,
    parameter int T_RAS  = 8,
    parameter int T_RC   = 11,
    parameter int T_WREC = 6,
    parameter int T_RTP  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             do_act,
    input  logic             do_rd,
    input  logic             do_wr,
    input  logic             do_ap,
    input  logic             do_pre,
    input  logic [ROW_W-1:0] act_row,
    output logic             open_o,
    output logic [ROW_W-1:0] row_o,
    output logic             act_ok,
    output logic             acc_ok,
    output logic             pre_ok
);
    localparam logic [CNT_W-1:0] L_RCD  = CNT_W'(T_RCD - 1);
    localparam logic [CNT_W-1:0] L_RP   = CNT_W'(T_RP - 1);
    localparam logic [CNT_W-1:0] L_RAS  = CNT_W'(T_RAS - 1);
    localparam logic [CNT_W-1:0] L_RC   = CNT_W'(T_RC - 1);
    localparam logic [CNT_W-1:0] L_WREC = CNT_W'(T_WREC - 1);
    localparam logic [CNT_W-1:0] L_RTP  = CNT_W'(T_RTP - 1);

    logic [CNT_W-1:0] rcd_q, pre_q, act_q, rcd_d, pre_d, act_d, pre_dec, act_dec;
    logic             open_q;
    logic [ROW_W-1:0] row_q;

    function automatic logic [CNT_W-1:0] dec(input logic [CNT_W-1:0] v);
        return (v == '0) ? v : v - CNT_W'(1);
    endfunction

    function automatic logic [CNT_W-1:0] mx(input logic [CNT_W-1:0] a, input logic [CNT_W-1:0] b);
        return (a > b) ? a : b;
    endfunction

    always_comb begin
        pre_dec = dec(pre_q);
        act_dec = dec(act_q);
        rcd_d   = dec(rcd_q);
        pre_d   = pre_dec;
        act_d   = act_dec;
        if (do_act) begin
            rcd_d = L_RCD;
            pre_d = L_RAS;
            act_d = L_RC;
        end
        if (do_wr) pre_d = mx(pre_dec, L_WREC);
        if (do_rd) pre_d = mx(pre_dec, L_RTP);
        // auto close lands one cycle after pre_d expires; reopen T_RP later
        if ((do_rd || do_wr) && do_ap) act_d = mx(act_dec, pre_d + CNT_W'(T_RP));
        if (do_pre) act_d = mx(act_dec, L_RP);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rcd_q  <= '0;
            pre_q  <= '0;
            act_q  <= '0;
            open_q <= 1'b0;
            row_q  <= '0;
        end else begin
            rcd_q <= rcd_d;
            pre_q <= pre_d;
            act_q <= act_d;
            if (do_act) begin
                open_q <= 1'b1;
                row_q  <= act_row;
            end else if (do_pre || ((do_rd || do_wr) && do_ap)) begin
                open_q <= 1'b0;
            end
        end
    end

    assign open_o = open_q;
    assign row_o  = row_q;
    assign act_ok = !open_q && (act_q == '0);
    assign acc_ok = open_q && (rcd_q == '0);
    assign pre_ok = (pre_q == '0);

    // R3
    act_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        do_act |-> !open_q);

    generate
        if (T_RCD >= 2) begin : g_rcd_chk
            // R4
            rcd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
                do_act |=> !(do_rd || do_wr));
        end
        if (T_RAS >= 2) begin : g_ras_chk
            // R5
            ras_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
                do_act |=> !do_pre);
        end
    endgenerate

endmodule

// File: rtl/dram_cmd_sched.sv
module dram_cmd_sched
    import dsched_pkg::*;
#(
    parameter int BA_W    = 2,
    parameter int ROW_W   = 13,
    parameter int COL_W   = 10,
    parameter int CNT_W   = 5,
    parameter int T_RCD   = 3,
    parameter int T_RP    = 3,
    parameter int T_RAS   = 8,
    parameter int T_RC    = 11,
    parameter int T_RRD   = 2,
    parameter int T_MRD   = 2,
    parameter int T_WR    = 3,
    parameter int T_WTR   = 2,
    parameter int T_WDATA = 3,
    parameter int T_RTP   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [1:0]       req_op,
    input  logic [BA_W-1:0]  req_bank,
    input  logic [ROW_W-1:0] req_row,
    input  logic [COL_W-1:0] req_col,
    input  logic             req_ap,
    output logic             cs_n,
    output logic             ras_n,
    output logic             cas_n,
    output logic             we_n,
    output logic [BA_W-1:0]  ba_o,
    output logic [ROW_W-1:0] addr_o
);
    localparam int NBANK  = 1 << BA_W;
    localparam int AP_BIT = 10;
    localparam logic [CNT_W-1:0] L_RRD = CNT_W'(T_RRD - 1);
    localparam logic [CNT_W-1:0] L_MRD = CNT_W'(T_MRD - 1);
    localparam logic [CNT_W-1:0] L_WTR = CNT_W'(T_WDATA + T_WTR - 1);

    st_t              state_q, state_d;
    op_t              h_op;
    logic [BA_W-1:0]  h_bank;
    logic [ROW_W-1:0] h_row;
    logic [COL_W-1:0] h_col;
    logic             h_ap;

    logic [NBANK-1:0] open_v, act_ok_v, acc_ok_v, pre_ok_v;
    logic [ROW_W-1:0] row_v [NBANK];
    logic             accept, fire_act, fire_acc, fire_pre, fire_all, fire_mode;
    logic             gate_ok, close_ok;
    logic [CNT_W-1:0] rrd_q, mrd_q, wtr_q;
    logic [3:0]       cmd_q;
    logic [BA_W-1:0]  ba_q;
    logic [ROW_W-1:0] addr_q, col_addr;

    function automatic logic [CNT_W-1:0] dec(input logic [CNT_W-1:0] v);
        return (v == '0) ? v : v - CNT_W'(1);
    endfunction

    generate
        for (genvar i = 0; i < NBANK; i++) begin : g_bank
            logic sel;
            assign sel = (h_bank == BA_W'(i));
            dsched_bank_timer #(
                .CNT_W(CNT_W), .ROW_W(ROW_W), .T_RCD(T_RCD), .T_RP(T_RP),
                .T_RAS(T_RAS), .T_RC(T_RC), .T_WREC(T_WDATA + T_WR), .T_RTP(T_RTP)
            ) u_tmr (
                .clk    (clk),
                .rst_n  (rst_n),
                .do_act (fire_act && sel),
                .do_rd  (fire_acc && sel && (h_op == OP_READ)),
                .do_wr  (fire_acc && sel && (h_op == OP_WRITE)),
                .do_ap  (h_ap),
                .do_pre ((fire_pre && sel) || fire_all),
                .act_row(h_row),
                .open_o (open_v[i]),
                .row_o  (row_v[i]),
                .act_ok (act_ok_v[i]),
                .acc_ok (acc_ok_v[i]),
                .pre_ok (pre_ok_v[i])
            );
        end
    endgenerate

    assign gate_ok   = (mrd_q == '0);
    assign close_ok  = &(pre_ok_v | ~open_v);
    assign req_ready = (state_q == ST_IDLE);

    always_comb begin
        state_d   = state_q;
        accept    = 1'b0;
        fire_act  = 1'b0;
        fire_acc  = 1'b0;
        fire_pre  = 1'b0;
        fire_all  = 1'b0;
        fire_mode = 1'b0;
        unique case (state_q)
            ST_IDLE: if (req_valid) begin
                accept = 1'b1;
                unique case (op_t'(req_op))
                    OP_READ, OP_WRITE: begin
                        if (!open_v[req_bank])                state_d = ST_OPEN;
                        else if (row_v[req_bank] != req_row) state_d = ST_CLOSE;
                        else                                  state_d = ST_ACCESS;
                    end
                    OP_PREALL: state_d = ST_ALLCLOSE;
                    default:   state_d = (|open_v) ? ST_ALLCLOSE : ST_MODE;
                endcase
            end
            ST_CLOSE: if (gate_ok && pre_ok_v[h_bank]) begin
                fire_pre = 1'b1;
                state_d  = ST_OPEN;
            end
            ST_OPEN: if (gate_ok && (rrd_q == '0) && act_ok_v[h_bank]) begin
                fire_act = 1'b1;
                state_d  = ST_ACCESS;
            end
            ST_ACCESS: if (gate_ok && acc_ok_v[h_bank] && ((h_op == OP_WRITE) || (wtr_q == '0))) begin
                fire_acc = 1'b1;
                state_d  = ST_IDLE;
            end
            ST_ALLCLOSE: if (gate_ok && close_ok) begin
                fire_all = 1'b1;
                state_d  = (h_op == OP_MODE) ? ST_MODE : ST_IDLE;
            end
            ST_MODE: if (gate_ok && (&act_ok_v)) begin
                fire_mode = 1'b1;
                state_d   = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            h_op    <= OP_READ;
            h_bank  <= '0;
            h_row   <= '0;
            h_col   <= '0;
            h_ap    <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                h_op   <= op_t'(req_op);
                h_bank <= req_bank;
                h_row  <= req_row;
                h_col  <= req_col;
                h_ap   <= req_ap;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rrd_q <= '0;
            mrd_q <= '0;
            wtr_q <= '0;
        end else begin
            rrd_q <= fire_act ? L_RRD : dec(rrd_q);
            mrd_q <= fire_mode ? L_MRD : dec(mrd_q);
            wtr_q <= (fire_acc && (h_op == OP_WRITE)) ? L_WTR : dec(wtr_q);
        end
    end

    always_comb begin
        col_addr              = '0;
        col_addr[COL_W-1:0]   = h_col;
        col_addr[AP_BIT]      = h_ap;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q  <= CMD_NOP;
            ba_q   <= '0;
            addr_q <= '0;
        end else begin
            cmd_q <= CMD_NOP;
            if (fire_act) begin
                cmd_q  <= CMD_ACT;
                ba_q   <= h_bank;
                addr_q <= h_row;
            end else if (fire_acc) begin
                cmd_q  <= (h_op == OP_WRITE) ? CMD_WR : CMD_RD;
                ba_q   <= h_bank;
                addr_q <= col_addr;
            end else if (fire_pre) begin
                cmd_q  <= CMD_PRE;
                ba_q   <= h_bank;
                addr_q <= '0;
            end else if (fire_all) begin
                cmd_q  <= CMD_PRE;
                ba_q   <= h_bank;
                addr_q <= ROW_W'(1) << AP_BIT;
            end else if (fire_mode) begin
                cmd_q  <= CMD_MRS;
                ba_q   <= h_bank;
                addr_q <= h_row;
            end
        end
    end

    assign {cs_n, ras_n, cas_n, we_n} = cmd_q;
    assign ba_o   = ba_q;
    assign addr_o = addr_q;

    // R12
    ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && !req_valid) |=> req_ready);

    generate
        if (T_MRD >= 2) begin : g_mrd_chk
            // R10
            mode_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (cmd_q == CMD_MRS) |=> (cmd_q == CMD_NOP));
        end
    endgenerate

endmodule

// File: tb/dram_cmd_sched_bench.sv
module dram_cmd_sched_bench;
    import dsched_pkg::*;

    localparam int T_RCD = 3, T_RP = 3, T_RAS = 8, T_RC = 11, T_RRD = 2;
    localparam int T_MRD = 2, T_WR = 3, T_WTR = 2, T_WDATA = 3, T_RTP = 2;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        req_valid = 1'b0, req_ap = 1'b0;
    logic        req_ready;
    logic [1:0]  req_op = 2'd0, req_bank = 2'd0;
    logic [12:0] req_row = '0;
    logic [9:0]  req_col = '0;
    logic        cs_n, ras_n, cas_n, we_n;
    logic [1:0]  ba_o;
    logic [12:0] addr_o;

    always #10 clk = ~clk;

    dram_cmd_sched #(
        .T_RCD(T_RCD), .T_RP(T_RP), .T_RAS(T_RAS), .T_RC(T_RC), .T_RRD(T_RRD),
        .T_MRD(T_MRD), .T_WR(T_WR), .T_WTR(T_WTR), .T_WDATA(T_WDATA), .T_RTP(T_RTP)
    ) u_dram_cmd_sched (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
        .req_ap(req_ap), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .ba_o(ba_o), .addr_o(addr_o)
    );

    int total = 0, bad = 0;
    int cyc = 0, n_cmds = 0;
    int t_act[4], t_pre[4], t_rd[4], t_wr[4], m_row[4];
    bit m_open[4];
    int t_act_any = -1000, t_wr_any = -1000, t_mrs = -1000;
    int lt_act, lt_rd, lt_wr, lt_pre, lt_mrs;
    logic [3:0]  last_cmd;
    logic [1:0]  last_ba;
    logic [12:0] last_addr;
    bit rq_open[4];
    int rq_row[4];
    bit done = 0;

    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    initial begin
        for (int i = 0; i < 4; i++) begin
            t_act[i] = -1000; t_pre[i] = -1000; t_rd[i] = -1000; t_wr[i] = -1000;
            m_row[i] = 0; m_open[i] = 0; rq_open[i] = 0; rq_row[i] = 0;
        end
    end

    // spacing-rule monitor on the command pins
    always @(negedge clk) begin
        if (rst_n) begin
            logic [3:0] c;
            int b;
            cyc++;
            c = {cs_n, ras_n, cas_n, we_n};
            b = int'(ba_o);
            if (c != CMD_NOP) begin
                n_cmds++;
                last_cmd = c; last_ba = ba_o; last_addr = addr_o;
                chk(cyc - t_mrs >= T_MRD, "R10", cyc - t_mrs, T_MRD);
                case (c)
                    CMD_ACT: begin
                        chk(!m_open[b], "R3", int'(m_open[b]), 0);
                        chk(cyc - t_act[b] >= T_RC, "R5", cyc - t_act[b], T_RC);
                        chk(cyc - t_pre[b] >= T_RP, "R5", cyc - t_pre[b], T_RP);
                        chk(cyc - t_act_any >= T_RRD, "R6", cyc - t_act_any, T_RRD);
                        m_open[b] = 1; m_row[b] = int'(addr_o);
                        t_act[b] = cyc; t_act_any = cyc; lt_act = cyc;
                    end
                    CMD_RD, CMD_WR: begin
                        chk(m_open[b], "R3", int'(m_open[b]), 1);
                        chk(cyc - t_act[b] >= T_RCD, "R4", cyc - t_act[b], T_RCD);
                        if (c == CMD_RD) begin
                            chk(cyc - t_wr_any >= T_WDATA + T_WTR, "R7", cyc - t_wr_any, T_WDATA + T_WTR);
                            t_rd[b] = cyc; lt_rd = cyc;
                        end else begin
                            t_wr[b] = cyc; t_wr_any = cyc; lt_wr = cyc;
                        end
                        if (addr_o[10]) begin
                            m_open[b] = 0;
                            t_pre[b] = mx(t_act[b] + T_RAS,
                                          (c == CMD_RD) ? cyc + T_RTP : cyc + T_WDATA + T_WR);
                        end
                    end
                    CMD_PRE: begin
                        for (int k = 0; k < 4; k++) begin
                            if (addr_o[10] ? m_open[k] : (k == b)) begin
                                chk(m_open[k], "R3", int'(m_open[k]), 1);
                                chk(cyc - t_act[k] >= T_RAS, "R5", cyc - t_act[k], T_RAS);
                                chk(cyc - t_wr[k] >= T_WDATA + T_WR, "R7", cyc - t_wr[k], T_WDATA + T_WR);
                                chk(cyc - t_rd[k] >= T_RTP, "R7", cyc - t_rd[k], T_RTP);
                                m_open[k] = 0; t_pre[k] = cyc;
                            end
                        end
                        lt_pre = cyc;
                    end
                    CMD_MRS: begin
                        for (int k = 0; k < 4; k++) begin
                            chk(!m_open[k], "R10", int'(m_open[k]), 0);
                            chk(cyc - t_pre[k] >= T_RP, "R10", cyc - t_pre[k], T_RP);
                        end
                        t_mrs = cyc; lt_mrs = cyc;
                    end
                    default: chk(0, "R2", int'(c), int'(CMD_NOP));
                endcase
            end
        end
    end

    // issue one request and check its command sequence; called just after a negedge
    task automatic do_req(input int op, input int bank, input int row, input int col, input bit ap);
        int start, ncmd, exp;
        bit any_open;
        any_open = 0;
        for (int k = 0; k < 4; k++) any_open |= rq_open[k];
        if (op <= 1) exp = !rq_open[bank] ? 2 : (rq_row[bank] != row) ? 3 : 1;
        else if (op == 2) exp = 1;
        else exp = any_open ? 2 : 1;
        start = n_cmds;
        req_valid = 1; req_op = 2'(op); req_bank = 2'(bank);
        req_row = 13'(row); req_col = 10'(col); req_ap = ap;
        while (!req_ready) begin @(negedge clk); #1; end
        @(posedge clk); #1;
        req_valid = 0;
        @(negedge clk); #1;
        chk(!req_ready, "R12", int'(req_ready), 0);
        while (!req_ready) begin @(negedge clk); #1; end
        ncmd = n_cmds - start;
        if (op <= 1) begin
            chk(ncmd == exp, "R3", ncmd, exp);
            chk(last_cmd == ((op == 0) ? CMD_RD : CMD_WR), "R3", int'(last_cmd), op);
            chk(int'(last_ba) == bank, "R3", int'(last_ba), bank);
            chk(int'(last_addr[9:0]) == col, "R3", int'(last_addr[9:0]), col);
            chk(last_addr[10] == ap, "R8", int'(last_addr[10]), int'(ap));
            chk(m_row[bank] == row, "R3", m_row[bank], row);
            rq_open[bank] = !ap; rq_row[bank] = row;
        end else if (op == 2) begin
            chk(ncmd == 1, "R9", ncmd, 1);
            chk(last_cmd == CMD_PRE && last_addr[10], "R9", int'(last_addr[10]), 1);
            for (int k = 0; k < 4; k++) rq_open[k] = 0;
        end else begin
            chk(ncmd == exp, "R10", ncmd, exp);
            chk(last_cmd == CMD_MRS, "R10", int'(last_cmd), int'(CMD_MRS));
            chk(int'(last_addr) == row && int'(last_ba) == bank, "R10", int'(last_addr), row);
            for (int k = 0; k < 4; k++) rq_open[k] = 0;
        end
    endtask

    initial begin
        int a1;
        void'($urandom(32'd4242));
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk); #1;
        // R1: reset state
        chk({cs_n, ras_n, cas_n, we_n} == CMD_NOP, "R1", int'({cs_n, ras_n, cas_n, we_n}), int'(CMD_NOP));
        chk(req_ready, "R1", int'(req_ready), 1);

        // R4 R11: open then read, exact spacing
        do_req(0, 0, 5, 18, 0);
        chk(lt_rd - lt_act == T_RCD, "R11", lt_rd - lt_act, T_RCD);

        // R8: write with auto close, then reopen same bank
        do_req(1, 1, 7, 3, 1);
        a1 = lt_act;
        chk(lt_wr - a1 == T_RCD, "R11", lt_wr - a1, T_RCD);
        do_req(0, 1, 7, 4, 0);
        chk(lt_act - a1 == mx(T_RC, mx(T_RAS, T_RCD + T_WDATA + T_WR) + T_RP), "R8",
            lt_act - a1, mx(T_RC, mx(T_RAS, T_RCD + T_WDATA + T_WR) + T_RP));

        // R3 R5: row miss, close-to-open exact
        do_req(0, 1, 9, 5, 0);
        chk(lt_act - lt_pre == T_RP, "R5", lt_act - lt_pre, T_RP);

        // R7: write-to-read turnaround across banks
        do_req(1, 1, 9, 6, 0);
        do_req(0, 0, 5, 7, 0);
        chk(lt_rd - lt_wr == T_WDATA + T_WTR, "R7", lt_rd - lt_wr, T_WDATA + T_WTR);

        // R9: close all, then a read must reopen
        do_req(2, 0, 0, 0, 0);
        do_req(0, 0, 5, 8, 0);

        // R10: mode load with a bank open, then a prompt open
        do_req(3, 1, 13'h0123, 0, 0);
        do_req(1, 2, 1, 9, 0);
        chk(lt_act - lt_mrs == T_MRD, "R10", lt_act - lt_mrs, T_MRD);

        // random mix
        for (int n = 0; n < 200; n++) begin
            int r, op;
            r = $urandom % 10;
            op = (r < 4) ? 0 : (r < 8) ? 1 : (r == 8) ? 2 : 3;
            if (op == 3) do_req(op, $urandom % 4, $urandom % 8192, 0, 0);
            else do_req(op, $urandom % 4, $urandom % 3, $urandom % 1024, ($urandom % 4) == 0);
            repeat ($urandom % 3) @(negedge clk);
            #1;
        end
        repeat (20) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            chk(0, "watchdog", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule